// File: doc/BRIEF.md
# Condition-Code Branch and Counted-Loop Unit

This unit decides where the program counter goes next for the control-transfer instructions of a small 16-bit processor. It holds the program counter itself. For a conditional branch it evaluates one of sixteen conditions over the carry, overflow, zero and negative flags, then either adds a signed displacement to the address after the instruction or steps past it. Short branches are two bytes long and carry an 8-bit displacement. Long branches are three bytes long and carry a 16-bit displacement.

The unit also runs a three-byte counted-loop instruction. Its first byte names an early-exit test on the Z flag. Its second byte selects one of eight 16-bit general registers. Its third byte is a signed backward or forward displacement. If the exit test passes, execution simply moves on. If not, the selected register is read through a combinational read port. The value minus one is written back, Z reports whether that result is zero, and the loop branches again while the result is nonzero.

All outputs are registered. A new program counter, a register write-back, a Z update or an illegal-encoding pulse all appear together one clock after the edge that samples the instruction. Instruction fetch and the ALU that produces the flags lie outside this block.

Top module: `cc_branch_unit`

## Requirements
- R1: During and right after reset, `pc_o` equals the RESET_PC parameter (0x1000 by default), and `wb_en`, `z_wr` and `illegal` are 0.
- R2: In a cycle with `instr_valid` low, the next clock edge leaves `pc_o` unchanged and produces no write-back.
- R3: Branch conditions by the 4-bit code (C, Z being flags): 0x0 always, 0x1 never, 0x2 C=0 and Z=0, 0x3 C=1 or Z=1, 0x4 C=0, 0x5 C=1, 0x6 Z=0, 0x7 Z=1.
- R4: Branch conditions by code (V, N, Z being flags): 0x8 V=0, 0x9 V=1, 0xA N=0, 0xB N=1, 0xC N=V, 0xD N≠V, 0xE Z=0 and N=V, 0xF Z=1 or N≠V.
- R5: A short branch (`is_loop`=0, `is_long`=0) moves to PC+2 plus the sign-extended `disp_in[7:0]` when taken, and to PC+2 otherwise. Both wrap modulo 2^16, and `disp_in[15:8]` has no effect.
- R6: A long branch (`is_loop`=0, `is_long`=1) moves to PC+3 plus `disp_in[15:0]` when taken, and to PC+3 otherwise, modulo 2^16.
- R7: A loop instruction (`is_loop`=1) is legal only if `loop_op` is 0x01, 0x06 or 0x07 and `loop_sel[7:3]`=5'b10111 (0xB8 to 0xBF). `reg_rd_idx` always equals `loop_sel[2:0]` combinationally, and a write-back goes to that index.
- R8: Exit test: 0x01 never exits, 0x06 exits when `flag_z`=0, and 0x07 exits when `flag_z`=1. On exit the PC becomes PC+3 and there is no write-back and no Z update.
- R9: A legal loop that does not exit writes `reg_rd_data`−1 (modulo 2^16) and drives `z_wr`=1 with `z_val`=1 exactly when that result is 0. The PC becomes PC+3 plus the sign-extended `disp_in[7:0]` if the result is nonzero, and PC+3 if it is zero.
- R10: An illegal loop encoding pulses `illegal` for one cycle and moves the PC to PC+3, with no write-back and no Z update.
- R11: `wb_en`, `z_wr` and `illegal` are one-cycle pulses. They appear in the cycle after the edge that samples `instr_valid` high, together with the new `pc_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A control-transfer instruction is presented this cycle |
| is_loop | input | 1 | 1 = counted-loop instruction, 0 = branch |
| is_long | input | 1 | For branches: 1 = 16-bit displacement, 0 = 8-bit |
| cond_code | input | 4 | Branch condition selector |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| disp_in | input | 16 | Displacement; the low byte only for short branches and loops |
| loop_op | input | 8 | Loop opcode byte |
| loop_sel | input | 8 | Loop register-select byte |
| reg_rd_idx | output | 3 | Index of the loop register to read |
| reg_rd_data | input | 16 | Value of the selected register |
| pc_o | output | 16 | Current program counter |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 3 | Write-back register index |
| wb_data | output | 16 | Write-back value |
| z_wr | output | 1 | Z flag update strobe |
| z_val | output | 1 | New Z flag value |
| illegal | output | 1 | Illegal loop encoding pulse |

## Verification
Every one of the sixteen condition codes is tried against all sixteen combinations of the four flags. This exposes any condition that reads the wrong flag, inverts a test, or mixes up AND and OR in the compound codes. Branches placed near both ends of the address space, with extreme positive and negative displacements and garbage in the unused upper displacement byte, show whether sign extension, instruction length and wrap-around are right. Loops are run to completion from a small count, from a count of zero (which wraps to 0xFFFF), from each register index, under each exit opcode with both Z values, and with malformed opcode and select bytes. These runs separate the exit path, the decrement path, the fall-through at zero and the illegal path from each other.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

    localparam int REG_SEL_W = 3;

    localparam logic [7:0] LOOP_OP_NOEXIT  = 8'h01;
    localparam logic [7:0] LOOP_OP_EXIT_ZC = 8'h06;
    localparam logic [7:0] LOOP_OP_EXIT_ZS = 8'h07;
    localparam logic [4:0] LOOP_SEL_PREFIX = 5'b10111;

    localparam int SHORT_LEN = 2;
    localparam int LONG_LEN  = 3;
    localparam int LOOP_LEN  = 3;

    typedef struct packed {
        logic c;
        logic v;
        logic z;
        logic n;
    } ccr_t;

    typedef enum logic [3:0] {
        CND_ALWAYS = 4'h0,
        CND_NEVER  = 4'h1,
        CND_HIGHER = 4'h2,
        CND_LOWSAM = 4'h3,
        CND_CCLR   = 4'h4,
        CND_CSET   = 4'h5,
        CND_NEQ    = 4'h6,
        CND_EQ     = 4'h7,
        CND_VCLR   = 4'h8,
        CND_VSET   = 4'h9,
        CND_POS    = 4'hA,
        CND_NEG    = 4'hB,
        CND_GE     = 4'hC,
        CND_LT     = 4'hD,
        CND_GT     = 4'hE,
        CND_LE     = 4'hF
    } cond_e;

endpackage

// File: rtl/cbl_cond_eval.sv
module cbl_cond_eval
    import cbl_pkg::*;
(
    input  ccr_t       flags_i,
    input  logic [3:0] code_i,
    output logic       taken_o
);

    logic n_eq_v;

    always_comb begin
        n_eq_v = (flags_i.n == flags_i.v);
        case (cond_e'(code_i))
            CND_ALWAYS: taken_o = 1'b1;
            CND_NEVER:  taken_o = 1'b0;
            CND_HIGHER: taken_o = !flags_i.c && !flags_i.z;
            CND_LOWSAM: taken_o = flags_i.c || flags_i.z;
            CND_CCLR:   taken_o = !flags_i.c;
            CND_CSET:   taken_o = flags_i.c;
            CND_NEQ:    taken_o = !flags_i.z;
            CND_EQ:     taken_o = flags_i.z;
            CND_VCLR:   taken_o = !flags_i.v;
            CND_VSET:   taken_o = flags_i.v;
            CND_POS:    taken_o = !flags_i.n;
            CND_NEG:    taken_o = flags_i.n;
            CND_GE:     taken_o = n_eq_v;
            CND_LT:     taken_o = !n_eq_v;
            CND_GT:     taken_o = !flags_i.z && n_eq_v;
            CND_LE:     taken_o = flags_i.z || !n_eq_v;
            default:    taken_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cbl_target_calc.sv
module cbl_target_calc #(
    parameter int ADDR_W   = 16,
    parameter int DISP_W   = 8,
    parameter int INSN_LEN = 2
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] seq_o,
    output logic [ADDR_W-1:0] target_o
);

    logic [ADDR_W-1:0] disp_ext;

    generate
        if (DISP_W < ADDR_W) begin : g_sext
            assign disp_ext = {{(ADDR_W - DISP_W){disp_i[DISP_W-1]}}, disp_i};
        end else begin : g_full
            assign disp_ext = disp_i[ADDR_W-1:0];
        end
    endgenerate

    assign seq_o    = pc_i + ADDR_W'(INSN_LEN);
    assign target_o = seq_o + disp_ext;

endmodule

// File: rtl/cbl_loop_ctrl.sv
module cbl_loop_ctrl
    import cbl_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [7:0]           op_i,
    input  logic [7:0]           sel_i,
    input  logic                 z_i,
    input  logic [DATA_W-1:0]    reg_val_i,
    output logic                 legal_o,
    output logic                 exit_o,
    output logic [REG_SEL_W-1:0] idx_o,
    output logic [DATA_W-1:0]    dec_val_o,
    output logic                 dec_zero_o
);

    logic op_ok;
    logic sel_ok;

    always_comb begin
        op_ok  = (op_i == LOOP_OP_NOEXIT) || (op_i == LOOP_OP_EXIT_ZC) ||
                 (op_i == LOOP_OP_EXIT_ZS);
        sel_ok = (sel_i[7:3] == LOOP_SEL_PREFIX);
        legal_o = op_ok && sel_ok;
        exit_o  = ((op_i == LOOP_OP_EXIT_ZC) && !z_i) ||
                  ((op_i == LOOP_OP_EXIT_ZS) && z_i);
        idx_o      = sel_i[REG_SEL_W-1:0];
        dec_val_o  = reg_val_i - DATA_W'(1);
        dec_zero_o = (dec_val_o == '0);
    end

endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
    import cbl_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 16,
    parameter int                SDISP_W  = 8,
    parameter logic [ADDR_W-1:0] RESET_PC = 16'h1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic                 is_loop,
    input  logic                 is_long,
    input  logic [3:0]           cond_code,
    input  logic                 flag_c,
    input  logic                 flag_v,
    input  logic                 flag_z,
    input  logic                 flag_n,
    input  logic [ADDR_W-1:0]    disp_in,
    input  logic [7:0]           loop_op,
    input  logic [7:0]           loop_sel,
    output logic [REG_SEL_W-1:0] reg_rd_idx,
    input  logic [DATA_W-1:0]    reg_rd_data,
    output logic [ADDR_W-1:0]    pc_o,
    output logic                 wb_en,
    output logic [REG_SEL_W-1:0] wb_idx,
    output logic [DATA_W-1:0]    wb_data,
    output logic                 z_wr,
    output logic                 z_val,
    output logic                 illegal
);

    typedef struct packed {
        logic [ADDR_W-1:0]    pc;
        logic                 wb_en;
        logic [REG_SEL_W-1:0] wb_idx;
        logic [DATA_W-1:0]    wb_data;
        logic                 z_wr;
        logic                 z_val;
        logic                 illegal;
    } state_t;

    state_t st_d, st_q;

    ccr_t              flags;
    logic              br_taken;
    logic [ADDR_W-1:0] short_seq, short_tgt;
    logic [ADDR_W-1:0] long_seq, long_tgt;
    logic [ADDR_W-1:0] loop_seq, loop_tgt;
    logic              lp_legal, lp_exit, lp_zero;
    logic [DATA_W-1:0] lp_dec;

    assign flags = '{c: flag_c, v: flag_v, z: flag_z, n: flag_n};

    cbl_cond_eval u_cond (
        .flags_i (flags),
        .code_i  (cond_code),
        .taken_o (br_taken)
    );

    cbl_target_calc #(.ADDR_W(ADDR_W), .DISP_W(SDISP_W), .INSN_LEN(SHORT_LEN)) u_short (
        .pc_i     (st_q.pc),
        .disp_i   (disp_in[SDISP_W-1:0]),
        .seq_o    (short_seq),
        .target_o (short_tgt)
    );

    cbl_target_calc #(.ADDR_W(ADDR_W), .DISP_W(ADDR_W), .INSN_LEN(LONG_LEN)) u_long (
        .pc_i     (st_q.pc),
        .disp_i   (disp_in),
        .seq_o    (long_seq),
        .target_o (long_tgt)
    );

    cbl_target_calc #(.ADDR_W(ADDR_W), .DISP_W(SDISP_W), .INSN_LEN(LOOP_LEN)) u_loop_tgt (
        .pc_i     (st_q.pc),
        .disp_i   (disp_in[SDISP_W-1:0]),
        .seq_o    (loop_seq),
        .target_o (loop_tgt)
    );

    cbl_loop_ctrl #(.DATA_W(DATA_W)) u_loop (
        .op_i       (loop_op),
        .sel_i      (loop_sel),
        .z_i        (flag_z),
        .reg_val_i  (reg_rd_data),
        .legal_o    (lp_legal),
        .exit_o     (lp_exit),
        .idx_o      (reg_rd_idx),
        .dec_val_o  (lp_dec),
        .dec_zero_o (lp_zero)
    );

    always_comb begin
        st_d         = st_q;
        st_d.wb_en   = 1'b0;
        st_d.z_wr    = 1'b0;
        st_d.illegal = 1'b0;
        if (instr_valid) begin
            if (is_loop) begin
                if (!lp_legal) begin
                    st_d.pc      = loop_seq;
                    st_d.illegal = 1'b1;
                end else if (lp_exit) begin
                    st_d.pc = loop_seq;
                end else begin
                    st_d.wb_en   = 1'b1;
                    st_d.wb_idx  = reg_rd_idx;
                    st_d.wb_data = lp_dec;
                    st_d.z_wr    = 1'b1;
                    st_d.z_val   = lp_zero;
                    st_d.pc      = lp_zero ? loop_seq : loop_tgt;
                end
            end else if (is_long) begin
                st_d.pc = br_taken ? long_tgt : long_seq;
            end else begin
                st_d.pc = br_taken ? short_tgt : short_seq;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o    = st_q.pc;
    assign wb_en   = st_q.wb_en;
    assign wb_idx  = st_q.wb_idx;
    assign wb_data = st_q.wb_data;
    assign z_wr    = st_q.z_wr;
    assign z_val   = st_q.z_val;
    assign illegal = st_q.illegal;

    assert_idle_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(pc_o) && !wb_en);

    assert_never_code_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !is_loop && !is_long && cond_code == 4'h1)
        |=> pc_o == $past(pc_o) + ADDR_W'(2));

    assert_exit_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && is_loop && lp_legal && lp_exit) |=> !wb_en && !z_wr);

    assert_wb_from_loop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> $past(instr_valid && is_loop));

    assert_zero_flag_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        z_wr |-> (z_val == (wb_data == '0)));

    assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wb_en && !z_wr);

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !wb_en && !z_wr && !illegal);

endmodule

// File: tb/cc_branch_unit_tb.sv
module cc_branch_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic        is_loop = 1'b0;
    logic        is_long = 1'b0;
    logic [3:0]  cond_code = '0;
    logic        flag_c = 1'b0, flag_v = 1'b0, flag_z = 1'b0, flag_n = 1'b0;
    logic [15:0] disp_in = '0;
    logic [7:0]  loop_op = '0;
    logic [7:0]  loop_sel = '0;
    logic [2:0]  reg_rd_idx;
    logic [15:0] reg_rd_data = '0;
    logic [15:0] pc_o;
    logic        wb_en;
    logic [2:0]  wb_idx;
    logic [15:0] wb_data;
    logic        z_wr, z_val, illegal;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_pc;

    always #5 clk = ~clk;

    cc_branch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .is_loop(is_loop),
        .is_long(is_long), .cond_code(cond_code), .flag_c(flag_c), .flag_v(flag_v),
        .flag_z(flag_z), .flag_n(flag_n), .disp_in(disp_in), .loop_op(loop_op),
        .loop_sel(loop_sel), .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
        .pc_o(pc_o), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .z_wr(z_wr), .z_val(z_val), .illegal(illegal)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic cond_ok(input logic [3:0] cc, input logic c, input logic v,
                                     input logic z, input logic n);
        case (cc)
            4'h0: return 1'b1;
            4'h1: return 1'b0;
            4'h2: return (c == 0) && (z == 0);
            4'h3: return (c == 1) || (z == 1);
            4'h4: return c == 0;
            4'h5: return c == 1;
            4'h6: return z == 0;
            4'h7: return z == 1;
            4'h8: return v == 0;
            4'h9: return v == 1;
            4'hA: return n == 0;
            4'hB: return n == 1;
            4'hC: return n == v;
            4'hD: return n != v;
            4'hE: return (z == 0) && (n == v);
            default: return (z == 1) || (n != v);
        endcase
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            instr_valid = 1'b0;
        end
    endtask

    task automatic do_branch(input logic lng, input logic [3:0] cc, input logic [3:0] cvzn,
                             input logic [15:0] disp, input string tag);
        logic tk;
        @(negedge clk);
        instr_valid = 1'b1; is_loop = 1'b0; is_long = lng; cond_code = cc;
        {flag_c, flag_v, flag_z, flag_n} = cvzn;
        disp_in = disp;
        @(posedge clk);
        #1;
        tk = cond_ok(cc, cvzn[3], cvzn[2], cvzn[1], cvzn[0]);
        if (lng) exp_pc = exp_pc + 16'd3 + (tk ? disp : 16'd0);
        else     exp_pc = exp_pc + 16'd2 + (tk ? {{8{disp[7]}}, disp[7:0]} : 16'd0);
        chk(tag, pc_o, exp_pc);
        chk({tag, " no wb R11"}, wb_en, 0);
    endtask

    task automatic jump_to(input logic [15:0] target);
        do_branch(1'b1, 4'h0, 4'h0, target - exp_pc - 16'd3, "R6 long jump");
    endtask

    task automatic do_loop(input logic [7:0] op, input logic [7:0] sel, input logic z,
                           input logic [15:0] rv, input logic [7:0] d8,
                           output logic [15:0] new_rv);
        logic legal, ex;
        logic [15:0] dec;
        legal = (op == 8'h01 || op == 8'h06 || op == 8'h07) && (sel[7:3] == 5'b10111);
        ex = (op == 8'h06 && !z) || (op == 8'h07 && z);
        dec = rv - 16'd1;
        @(negedge clk);
        instr_valid = 1'b1; is_loop = 1'b1; is_long = 1'b0; loop_op = op; loop_sel = sel;
        flag_z = z; reg_rd_data = rv; disp_in = {8'h5A, d8};
        #1;
        chk("R7 read index", reg_rd_idx, sel[2:0]);
        @(posedge clk);
        #1;
        new_rv = rv;
        if (!legal) begin
            exp_pc = exp_pc + 16'd3;
            chk("R10 illegal flag", illegal, 1);
            chk("R10 no wb", {wb_en, z_wr}, 0);
            chk("R10 pc", pc_o, exp_pc);
        end else if (ex) begin
            exp_pc = exp_pc + 16'd3;
            chk("R8 exit no wb/z", {wb_en, z_wr, illegal}, 0);
            chk("R8 exit pc", pc_o, exp_pc);
        end else begin
            new_rv = dec;
            exp_pc = exp_pc + 16'd3 + ((dec != 0) ? {{8{d8[7]}}, d8} : 16'd0);
            chk("R9 wb strobe", {wb_en, z_wr, illegal}, 3'b110);
            chk("R7 wb index", wb_idx, sel[2:0]);
            chk("R9 wb data", wb_data, dec);
            chk("R9 z value", z_val, dec == 0);
            chk("R9 pc", pc_o, exp_pc);
        end
        @(negedge clk);
        instr_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R11 pulse ends", {wb_en, z_wr, illegal}, 0);
        chk("R2 pc hold after loop", pc_o, exp_pc);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pc in reset", pc_o, 16'h1000);
        chk("R1 strobes in reset", {wb_en, z_wr, illegal}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        exp_pc = 16'h1000;
        chk("R1 pc after reset", pc_o, exp_pc);
        chk("R1 strobes after reset", {wb_en, z_wr, illegal}, 0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        is_long = 1'b1; cond_code = 4'h0; disp_in = 16'h0400;
        instr_valid = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk("R2 idle pc", pc_o, exp_pc);
        chk("R2 idle no wb", wb_en, 0);
    endtask

    task automatic t_cond_table();
        jump_to(16'h3000);
        for (int cc = 0; cc < 16; cc++) begin
            for (int f = 0; f < 16; f++) begin
                do_branch(1'b0, 4'(cc), 4'(f), 16'hAB06, (cc < 8) ? "R3 cond" : "R4 cond");
                do_branch(1'b0, 4'h0, 4'h0, 16'h00F8, "R5 return");
            end
        end
    endtask

    task automatic t_short_edges();
        jump_to(16'hFFF0);
        do_branch(1'b0, 4'h0, 4'h0, 16'hFF7F, "R5 forward wrap");
        chk("R5 wrap value", pc_o, 16'h0071);
        jump_to(16'h0010);
        do_branch(1'b0, 4'h0, 4'h0, 16'h0080, "R5 backward wrap");
        chk("R5 wrap back value", pc_o, 16'hFF92);
        do_branch(1'b0, 4'h1, 4'h0, 16'h0080, "R5 not taken");
    endtask

    task automatic t_long_edges();
        jump_to(16'h0100);
        do_branch(1'b1, 4'h7, 4'b0010, 16'h8000, "R6 big negative");
        chk("R6 value", pc_o, 16'h8103);
        do_branch(1'b1, 4'h6, 4'b0010, 16'h8000, "R6 not taken");
        jump_to(16'hFFFE);
        chk("R6 jump near top", pc_o, 16'hFFFE);
        do_branch(1'b1, 4'h1, 4'h0, 16'h1234, "R6 wrap fall");
        chk("R6 wrap fall value", pc_o, 16'h0001);
    endtask

    task automatic t_loop_count();
        logic [15:0] r, start;
        int iters;
        jump_to(16'h2000);
        start = exp_pc;
        r = 16'd3;
        iters = 0;
        while (r != 0 && iters < 10) begin
            do_loop(8'h01, 8'hB9, 1'b1, r, 8'hFD, r);
            iters++;
        end
        chk("R9 loop iterations", iters, 3);
        chk("R9 loop exit pc", pc_o, start + 16'd3);
    endtask

    task automatic t_loop_exit_modes();
        logic [15:0] r;
        do_loop(8'h06, 8'hBA, 1'b0, 16'h0005, 8'hF0, r);
        do_loop(8'h07, 8'hBA, 1'b1, 16'h0005, 8'hF0, r);
        do_loop(8'h06, 8'hBA, 1'b1, 16'h0005, 8'h10, r);
        do_loop(8'h07, 8'hBA, 1'b0, 16'h0002, 8'h10, r);
        do_loop(8'h01, 8'hBB, 1'b0, 16'h0001, 8'h10, r);
        do_loop(8'h01, 8'hBC, 1'b1, 16'h0000, 8'h80, r);
        chk("R9 wrap decrement", r, 16'hFFFF);
        jump_to(16'hFFFE);
        do_loop(8'h01, 8'hBD, 1'b0, 16'h0001, 8'h80, r);
        chk("R9 zero falls through with wrap", pc_o, 16'h0001);
    endtask

    task automatic t_loop_regsel();
        logic [15:0] r;
        for (int s = 8'hB8; s <= 8'hBF; s++) begin
            do_loop(8'h01, 8'(s), 1'b0, 16'h0100 + 16'(s), 8'h04, r);
        end
    endtask

    task automatic t_illegal();
        logic [15:0] r;
        do_loop(8'h02, 8'hB8, 1'b0, 16'h0009, 8'h04, r);
        do_loop(8'h01, 8'hB7, 1'b0, 16'h0009, 8'h04, r);
        do_loop(8'h07, 8'hC0, 1'b1, 16'h0009, 8'h04, r);
        do_loop(8'h00, 8'h38, 1'b0, 16'h0009, 8'h04, r);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_cond_table();
        t_short_edges();
        t_long_edges();
        t_loop_count();
        t_loop_exit_modes();
        t_loop_regsel();
        t_illegal();
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule